// File: doc/BRIEF.md
# I2C Register Access Slave

This block is a 7-bit-address I2C target that exposes a small bank of byte-wide registers to a bus controller. It watches the SCL and SDA lines, cleans them up with a two-flop synchronizer and a glitch filter, and pulls SDA low through an open-drain enable when it acknowledges or sends a zero bit. The upper six address bits are a parameter. The lowest address bit comes from a strap input, so two copies can share one bus.

A controller writes by sending START, the device address with the write bit, a sub-address byte and then any number of data bytes. It reads by sending the sub-address in the same way, then a repeated START and the device address with the read bit. The target then returns bytes until the controller answers one with a not-acknowledge. The top bit of the sub-address byte asks for the register pointer to advance after every byte. The low bits choose the first register. Clock stretching, general call and 10-bit addressing are not provided.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset the SDA drive enable is low and every register reads as 0x00.
- R2: An address byte whose upper seven bits (first seven bits on the wire) equal {DEV_ADDR_HI, addrStrap} is acknowledged by holding SDA low during the ninth clock. Bit 0 of that byte selects write (0) or read (1).
- R3: An address byte that does not match is not acknowledged. SDA stays released for the rest of that transfer, and no register changes.
- R4: The byte after a write address is the sub-address and is acknowledged. Bit 7 set to 1 enables auto-increment. The register index is the low REG_ADDR_W bits of bits 6..0.
- R5: Each data byte after the sub-address is received MSB first, acknowledged, and stored in the register the pointer selects.
- R6: With auto-increment, the pointer advances by one after each byte written or each read byte the controller acknowledges, wrapping modulo 2**REG_ADDR_W. Without it, the pointer stays on one register.
- R7: After a repeated START with the read bit, the target sends the pointed register MSB first, changing SDA only while SCL is low, and sends another byte after each controller acknowledge.
- R8: When the controller does not acknowledge a read byte, the target releases SDA and drives nothing until the next START.
- R9: A START or repeated START restarts the bit count at an address byte. A STOP returns the target to idle and discards any partly received byte.
- R10: A pulse on SCL or SDA that lasts fewer than FILT_LEN clock cycles after synchronization has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, sampling the bus lines |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| addrStrap | input | 1 | Least significant bit of the device address |
| sdaOe | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The bench walks the register pointer across the top of the bank to confirm that it wraps to zero. A design that saturated the pointer or carried into an unused bit would return the wrong register. It reads one register twice without auto-increment to catch a pointer that advances anyway. After a not-acknowledge it clocks an extra bit over a register holding zero, so a target that kept sending would pull the line low. It restarts in the middle of an address and stops in the middle of a data byte, which exposes a bit counter that is not cleared or a partial byte that still gets stored. It also adds one-cycle SCL spikes during a data byte, which a missing filter would count as extra bits.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_SUB,
    ST_WR,
    ST_TX,
    ST_TX_END,
    ST_MACK,
    ST_MACK_OK
  } ctrl_state_t;

  typedef enum logic [1:0] {
    AK_ADDR_W,
    AK_ADDR_R,
    AK_DATA
  } ack_kind_t;

  // strobes from control to datapath, at most one cycle each
  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic writeReg;
    logic incPtr;
    logic loadTx;
    logic shiftOut;
  } dp_ctrl_t;

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic [1:0] lineSync,
  output logic [1:0] lineFilt,
  output logic       sclRise,
  output logic       sclFall,
  output logic       startDet,
  output logic       stopDet
);
  localparam int LINES = 2;
  localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);

  logic [LINES-1:0] rawIn;
  logic [1:0]       lineDly;

  assign rawIn = {sdaIn, sclIn};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic          meta;
    logic          syncQ;
    logic          filtQ;
    logic [CW-1:0] runCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta   <= 1'b1;
        syncQ  <= 1'b1;
        filtQ  <= 1'b1;
        runCnt <= '0;
      end else begin
        meta  <= rawIn[g];
        syncQ <= meta;
        if (syncQ == filtQ) begin
          runCnt <= '0;
        end else if (runCnt == CW'(FILT_LEN - 1)) begin
          filtQ  <= syncQ;
          runCnt <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end
    end

    assign lineSync[g] = syncQ;
    assign lineFilt[g] = filtQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineDly <= 2'b11;
    else       lineDly <= lineFilt;
  end

  // index 0 is SCL, index 1 is SDA
  assign sclRise  = lineFilt[0] & ~lineDly[0];
  assign sclFall  = ~lineFilt[0] & lineDly[0];
  assign startDet = lineFilt[0] & lineDly[0] & lineDly[1] & ~lineFilt[1];
  assign stopDet  = lineFilt[0] & lineDly[0] & ~lineDly[1] & lineFilt[1];

endmodule

// File: rtl/i2c_reg_datapath.sv
module i2c_reg_datapath
  import i2c_reg_pkg::*;
#(
  parameter int REG_ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dp_ctrl_t              dpCtl,
  input  logic                  sdaBit,
  output logic [7:0]            rxNext,
  output logic                  txBit,
  output logic                  autoInc,
  output logic [REG_ADDR_W-1:0] regPtr
);
  localparam int DEPTH = 1 << REG_ADDR_W;

  logic [7:0] rxShift;
  logic [7:0] txShift;
  logic [7:0] regFile [DEPTH];

  assign rxNext = {rxShift[6:0], sdaBit};
  assign txBit  = txShift[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= 8'hFF;
      autoInc <= 1'b0;
      regPtr  <= '0;
      for (int i = 0; i < DEPTH; i++) regFile[i] <= '0;
    end else begin
      if (dpCtl.shiftIn) rxShift <= rxNext;
      if (dpCtl.loadPtr) begin
        regPtr  <= rxNext[REG_ADDR_W-1:0];
        autoInc <= rxNext[7];
      end else if (dpCtl.incPtr) begin
        regPtr <= regPtr + 1'b1;
      end
      if (dpCtl.writeReg) regFile[regPtr] <= rxNext;
      if (dpCtl.loadTx)        txShift <= regFile[regPtr];
      else if (dpCtl.shiftOut) txShift <= {txShift[6:0], 1'b1};
    end
  end

endmodule

// File: rtl/i2c_reg_ctrl.sv
module i2c_reg_ctrl
  import i2c_reg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclRise,
  input  logic        sclFall,
  input  logic        startDet,
  input  logic        stopDet,
  input  logic        sdaF,
  input  logic [6:0]  devAddr,
  input  logic [7:0]  rxNext,
  input  logic        txBit,
  input  logic        autoInc,
  output dp_ctrl_t    dpCtl,
  output ctrl_state_t ctrlState,
  output logic        sdaOe
);
  ctrl_state_t stN;
  logic [2:0]  bitCnt, bitCntN;
  logic        ackOn, ackOnN;
  ack_kind_t   ackKind, ackKindN;

  always_comb begin
    stN      = ctrlState;
    bitCntN  = bitCnt;
    ackOnN   = ackOn;
    ackKindN = ackKind;
    dpCtl    = '0;
    if (stopDet) begin
      stN    = ST_IDLE;
      ackOnN = 1'b0;
    end else if (startDet) begin
      stN     = ST_ADDR;
      bitCntN = '0;
      ackOnN  = 1'b0;
    end else begin
      unique case (ctrlState)
        ST_ADDR: if (sclRise) begin
          dpCtl.shiftIn = 1'b1;
          if (bitCnt == 3'd7) begin
            if (rxNext[7:1] == devAddr) begin
              stN      = ST_ACK;
              ackKindN = rxNext[0] ? AK_ADDR_R : AK_ADDR_W;
            end else begin
              stN = ST_IDLE;
            end
          end else begin
            bitCntN = bitCnt + 3'd1;
          end
        end
        ST_ACK: if (sclFall) begin
          if (!ackOn) begin
            ackOnN = 1'b1;
          end else begin
            ackOnN  = 1'b0;
            bitCntN = '0;
            unique case (ackKind)
              AK_ADDR_W: stN = ST_SUB;
              AK_ADDR_R: begin
                stN          = ST_TX;
                dpCtl.loadTx = 1'b1;
              end
              default:   stN = ST_WR;
            endcase
          end
        end
        ST_SUB: if (sclRise) begin
          dpCtl.shiftIn = 1'b1;
          if (bitCnt == 3'd7) begin
            dpCtl.loadPtr = 1'b1;
            stN           = ST_ACK;
            ackKindN      = AK_DATA;
          end else begin
            bitCntN = bitCnt + 3'd1;
          end
        end
        ST_WR: if (sclRise) begin
          dpCtl.shiftIn = 1'b1;
          if (bitCnt == 3'd7) begin
            dpCtl.writeReg = 1'b1;
            dpCtl.incPtr   = autoInc;
            stN            = ST_ACK;
            ackKindN       = AK_DATA;
          end else begin
            bitCntN = bitCnt + 3'd1;
          end
        end
        ST_TX: begin
          if (sclRise) begin
            if (bitCnt == 3'd7) stN = ST_TX_END;
            else                bitCntN = bitCnt + 3'd1;
          end
          if (sclFall) dpCtl.shiftOut = 1'b1;
        end
        ST_TX_END: if (sclFall) stN = ST_MACK;
        ST_MACK: if (sclRise) begin
          if (sdaF) begin
            stN = ST_IDLE;
          end else begin
            dpCtl.incPtr = autoInc;
            stN          = ST_MACK_OK;
          end
        end
        ST_MACK_OK: if (sclFall) begin
          dpCtl.loadTx = 1'b1;
          bitCntN      = '0;
          stN          = ST_TX;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlState <= ST_IDLE;
      bitCnt    <= '0;
      ackOn     <= 1'b0;
      ackKind   <= AK_ADDR_W;
    end else begin
      ctrlState <= stN;
      bitCnt    <= bitCntN;
      ackOn     <= ackOnN;
      ackKind   <= ackKindN;
    end
  end

  assign sdaOe = ((ctrlState == ST_ACK) && ackOn) ||
                 (((ctrlState == ST_TX) || (ctrlState == ST_TX_END)) && !txBit);

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR_HI = 6'b001100,
  parameter int         REG_ADDR_W  = 4,
  parameter int         FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic addrStrap,
  output logic sdaOe
);
  logic [1:0]            lineSync;
  logic [1:0]            lineFilt;
  logic                  sclRise, sclFall, startDet, stopDet;
  dp_ctrl_t              dpCtl;
  ctrl_state_t           ctrlState;
  logic [7:0]            rxNext;
  logic                  txBit, autoInc;
  logic [REG_ADDR_W-1:0] regPtr;

  i2c_line_cond #(.FILT_LEN(FILT_LEN)) u_cond (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .lineSync(lineSync), .lineFilt(lineFilt),
    .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2c_reg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaF(lineFilt[1]),
    .devAddr({DEV_ADDR_HI, addrStrap}), .rxNext(rxNext), .txBit(txBit),
    .autoInc(autoInc), .dpCtl(dpCtl), .ctrlState(ctrlState), .sdaOe(sdaOe)
  );

  i2c_reg_datapath #(.REG_ADDR_W(REG_ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .sdaBit(lineFilt[1]),
    .rxNext(rxNext), .txBit(txBit), .autoInc(autoInc), .regPtr(regPtr)
  );

endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk
  import i2c_reg_pkg::*;
#(
  parameter int REG_ADDR_W = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sdaOe,
  input logic [1:0]            lineSync,
  input logic [1:0]            lineFilt,
  input ctrl_state_t           ctrlState,
  input logic [REG_ADDR_W-1:0] regPtr,
  input logic                  incPtr,
  input logic                  loadPtr,
  input logic                  autoInc
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !sdaOe); // R1

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_IDLE) |-> !sdaOe); // R3

  AST_NACK_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_MACK || ctrlState == ST_MACK_OK) |-> !sdaOe); // R8

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(incPtr) && !$past(loadPtr)) |-> regPtr == REG_ADDR_W'($past(regPtr) + 1'b1)); // R6

  AST_INC_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    incPtr |-> autoInc); // R6

  AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (lineFilt[0] && $past(lineFilt[0])) |-> $stable(sdaOe)); // R7

  AST_SCL_FILTER: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lineFilt[0]) |-> $past(lineSync[0]) == lineFilt[0]); // R10

  AST_SDA_FILTER: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lineFilt[1]) |-> $past(lineSync[1]) == lineFilt[1]); // R10

endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.REG_ADDR_W(REG_ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .lineSync(lineSync),
  .lineFilt(lineFilt), .ctrlState(ctrlState), .regPtr(regPtr),
  .incPtr(dpCtl.incPtr), .loadPtr(dpCtl.loadPtr), .autoInc(autoInc)
);

// File: tb/i2c_reg_slave_bench.sv
module i2c_reg_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam logic [5:0] ADDR_HI = 6'b001100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSdaLow = 1'b0;
  logic strap = 1'b0;
  logic sdaOe;
  wire  sdaBus = !(mSdaLow || sdaOe);

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_reg_slave u_i2c_reg_slave (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus),
    .addrStrap(strap), .sdaOe(sdaOe)
  );

  typedef struct {
    string      req;
    logic [7:0] val;
  } item_t;

  item_t      expQ[$];
  logic [7:0] obsQ[$];
  int         nVec = 0;
  int         nErr = 0;
  logic [7:0] model [16];
  bit         done = 0;

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (obsQ.size() > 0) begin
        item_t      e;
        logic [7:0] a;
        a = obsQ.pop_front();
        nVec++;
        if (expQ.size() == 0) begin
          nErr++;
          $display("FAIL %s: actual %02h expected none", "scoreboard", a);
        end else begin
          e = expQ.pop_front();
          if (a !== e.val) begin
            nErr++;
            $display("FAIL %s: actual %02h expected %02h", e.req, a, e.val);
          end
        end
      end
    end
  end

  task automatic expect_(input string req, input logic [7:0] v);
    item_t it;
    it.req = req;
    it.val = v;
    expQ.push_back(it);
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mSdaLow = 1'b0; mScl = 1'b1; qwait();
    mSdaLow = 1'b1; qwait();
    mScl = 1'b0; qwait();
  endtask

  task automatic busRestart();
    mSdaLow = 1'b0; qwait();
    mScl = 1'b1; qwait();
    mSdaLow = 1'b1; qwait();
    mScl = 1'b0; qwait();
  endtask

  task automatic busStop();
    mSdaLow = 1'b1; qwait();
    mScl = 1'b1; qwait();
    mSdaLow = 1'b0; qwait();
  endtask

  task automatic putBit(input logic b, input bit glitch);
    mSdaLow = !b;
    if (glitch) begin
      repeat (Q / 2) @(negedge clk);
      mScl = 1'b1; @(negedge clk); mScl = 1'b0;
      repeat (Q - Q / 2 - 1) @(negedge clk);
    end else begin
      qwait();
    end
    mScl = 1'b1; qwait(); qwait();
    mScl = 1'b0; qwait();
  endtask

  task automatic getBit(output logic b);
    mSdaLow = 1'b0; qwait();
    mScl = 1'b1; qwait();
    b = sdaBus; qwait();
    mScl = 1'b0; qwait();
  endtask

  task automatic sendByte(input logic [7:0] v, input logic expAck, input string req,
                          input bit glitch);
    logic a;
    for (int i = 7; i >= 0; i--) putBit(v[i], glitch);
    getBit(a);
    expect_(req, {7'd0, expAck});
    obsQ.push_back({7'd0, a});
  endtask

  task automatic recvByte(input logic [7:0] expv, input bit nack, input string req);
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) getBit(got[i]);
    putBit(nack, 1'b0);
    expect_(req, expv);
    obsQ.push_back(got);
  endtask

  function automatic logic [7:0] devW();
    return {ADDR_HI, strap, 1'b0};
  endfunction

  task automatic wrBurst(input logic [7:0] sub, input int n,
                         input logic [7:0] d0, input logic [7:0] d1,
                         input logic [7:0] d2);
    logic [7:0] d[3];
    logic [3:0] p;
    d[0] = d0; d[1] = d1; d[2] = d2;
    p = sub[3:0];
    busStart();
    sendByte(devW(), 1'b0, "R2", 1'b0);
    sendByte(sub, 1'b0, "R4", 1'b0);
    for (int k = 0; k < n; k++) begin
      sendByte(d[k], 1'b0, "R5", 1'b0);
      model[p] = d[k];
      if (sub[7]) p = p + 1'b1;
    end
    busStop();
  endtask

  task automatic rdBurst(input logic [7:0] sub, input int n, input string req);
    logic [3:0] p;
    p = sub[3:0];
    busStart();
    sendByte(devW(), 1'b0, "R2", 1'b0);
    sendByte(sub, 1'b0, "R4", 1'b0);
    busRestart();
    sendByte(devW() | 8'h01, 1'b0, "R7", 1'b0);
    for (int k = 0; k < n; k++) begin
      recvByte(model[p], k == n - 1, req);
      if (sub[7]) p = p + 1'b1;
    end
    busStop();
  endtask

  // watchdog
  initial begin
    repeat (180000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
    $finish;
  end

  initial begin
    logic b;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    // R1: reset state of the drive enable
    expect_("R1", 8'h00);
    obsQ.push_back({7'd0, sdaOe});
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    expect_("R1", 8'h01);
    obsQ.push_back({7'd0, sdaBus});

    // R1: a register reads zero after reset
    rdBurst(8'h0A, 1, "R1");

    // R5 R6 R7: auto-increment burst write then read back
    wrBurst(8'h83, 3, 8'hA1, 8'hB2, 8'hC3);
    rdBurst(8'h83, 3, "R7");

    // R6: fixed pointer, last write wins, repeat reads one register
    wrBurst(8'h05, 2, 8'h11, 8'h22, 8'h00);
    rdBurst(8'h05, 2, "R6");
    rdBurst(8'h06, 1, "R6");

    // R6: wrap from the top register to register 0
    wrBurst(8'h8F, 2, 8'h5A, 8'h6B, 8'h00);
    rdBurst(8'h8F, 2, "R6");

    // R4: only low bits of the sub-address index the bank
    wrBurst(8'h1A, 1, 8'h3C, 8'h00, 8'h00);
    rdBurst(8'h0A, 1, "R4");

    // R3: wrong address, nothing acknowledged, nothing stored
    busStart();
    sendByte({ADDR_HI ^ 6'b000001, strap, 1'b0}, 1'b1, "R3", 1'b0);
    sendByte(8'h09, 1'b1, "R3", 1'b0);
    sendByte(8'hEE, 1'b1, "R3", 1'b0);
    busStop();
    rdBurst(8'h09, 1, "R3");

    // R2: the strap sets the address LSB
    strap = 1'b1;
    repeat (3) @(negedge clk);
    busStart();
    sendByte({ADDR_HI, 1'b0, 1'b0}, 1'b1, "R2", 1'b0);
    busStop();
    wrBurst(8'h0B, 1, 8'h77, 8'h00, 8'h00);
    rdBurst(8'h0B, 1, "R2");

    // R8: after the not-acknowledge the target stays silent
    busStart();
    sendByte(devW(), 1'b0, "R2", 1'b0);
    sendByte(8'h0C, 1'b0, "R4", 1'b0);
    busRestart();
    sendByte(devW() | 8'h01, 1'b0, "R7", 1'b0);
    recvByte(model[12], 1'b1, "R8");
    getBit(b);
    expect_("R8", 8'h01);
    obsQ.push_back({7'd0, b});
    getBit(b);
    expect_("R8", 8'h01);
    obsQ.push_back({7'd0, b});
    busStop();

    // R9: repeated START in the middle of an address byte
    busStart();
    putBit(1'b0, 1'b0); putBit(1'b1, 1'b0); putBit(1'b1, 1'b0);
    busRestart();
    sendByte(devW(), 1'b0, "R9", 1'b0);
    sendByte(8'h0D, 1'b0, "R9", 1'b0);
    sendByte(8'h4E, 1'b0, "R9", 1'b0);
    model[13] = 8'h4E;
    busStop();
    rdBurst(8'h0D, 1, "R9");

    // R9: STOP in the middle of a data byte discards it
    busStart();
    sendByte(devW(), 1'b0, "R2", 1'b0);
    sendByte(8'h07, 1'b0, "R4", 1'b0);
    putBit(1'b1, 1'b0); putBit(1'b0, 1'b0); putBit(1'b1, 1'b0); putBit(1'b1, 1'b0);
    busStop();
    rdBurst(8'h07, 1, "R9");

    // R10: single-cycle SCL spikes inside each data bit
    busStart();
    sendByte(devW(), 1'b0, "R2", 1'b0);
    sendByte(8'h02, 1'b0, "R4", 1'b0);
    sendByte(8'h96, 1'b0, "R10", 1'b1);
    model[2] = 8'h96;
    busStop();
    rdBurst(8'h02, 1, "R10");

    done = 1;
    repeat (5) @(negedge clk);
    if (expQ.size() != 0) begin
      nErr++;
      $display("FAIL scoreboard: actual %0d left expected 0", expQ.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
    $finish;
  end

endmodule